// File: doc/BRIEF.md
# Windowed Register File with Call/Return Remapping

This block is a register file in which each procedure activation sees a 32-entry logical register space. Part of that space is carved out of a larger physical array that holds one slice per procedure level. A bank of globals is shared by every level. Each level also has private locals. Its outgoing argument registers are the same storage as the next level's incoming argument registers, so a caller's arguments appear in the callee's window without any copy instruction.

A call strobe moves the current-window pointer forward around a ring of windows, and a return strobe moves it back. A second pointer marks the oldest window still held in the array. When a call would wrap onto that window, the block raises a spill request and holds the pointers until an external agent acknowledges that the window has been saved. When a return leaves the resident range, the block raises a fill request instead. The agent reads `cwp_o` and `swp_o` to know which slice to move. The memory transfer itself happens outside the block.

There are two read ports and one write port. Reads are registered, and a write that targets the same physical entry in the same cycle is forwarded to the read output.

Top module: `rwin_file`

## Requirements
- R1: Reset, which is synchronous and active high, sets both window pointers to 0, clears both requests and clears both read outputs.
- R2: Logical register 0 always reads as 0. A write to it changes nothing.
- R3: Logical registers 1 to 9 are one global bank, and reads of them return the same value in every window.
- R4: Logical registers 16 to 25 are private to each window. A value written in one window is still there after a call and the matching return, whatever the callee wrote to the same numbers.
- R5: Logical register 10+k of window w is the same storage as logical register 26+k of window w+1, for k = 0 to 5, in both directions.
- R6: Read data appears on the clock edge after the address is presented. When a write and a read address the same register in one cycle, the read returns the new data.
- R7: With no request pending, a call sets the current pointer to (cwp+1) mod 8 on the next edge, and a return sets it to (cwp-1) mod 8, provided neither one triggers R8 or R9.
- R8: A call with (cwp+1) mod 8 equal to the saved pointer raises `spill_req_o` on the next edge and leaves cwp unchanged. The edge that samples `spill_ack_i` high drops the request and advances both pointers by one.
- R9: A return with cwp equal to the saved pointer raises `fill_req_o` on the next edge and leaves cwp unchanged. The edge that samples `fill_ack_i` high drops the request and moves both pointers back by one.
- R10: While a request is pending, call and return strobes are ignored. If call and return arrive together, the call is taken and the return is ignored.
- R11: An acknowledge that arrives with no matching request pending changes neither pointer nor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| spill_ack_i | input | 1 | External agent has saved the oldest window |
| fill_ack_i | input | 1 | External agent has restored the window below the oldest |
| rs1_i | input | 5 | Logical read address, port 1 |
| rs2_i | input | 5 | Logical read address, port 2 |
| rd_i | input | 5 | Logical write address |
| we_i | input | 1 | Write enable |
| wd_i | input | DATA_W | Write data |
| rdata1_o | output | DATA_W | Registered read data, port 1 |
| rdata2_o | output | DATA_W | Registered read data, port 2 |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Oldest resident window pointer |
| spill_req_o | output | 1 | Window save needed before the call completes |
| fill_req_o | output | 1 | Window restore needed before the return completes |

## Verification
The properties assume that call and return are single-cycle strobes. They also assume that an acknowledge is held high only for the one cycle after the external agent has seen its request. Under these assumptions, a held acknowledge cannot complete a second transfer. The stimulus raises each acknowledge for exactly one cycle while its request is visible. The one exception is a deliberate stray acknowledge, sent while no request is pending to exercise R11, and the properties tolerate it because such an acknowledge must leave all state unchanged. Writes during a pending request use the unchanged pointer, so the data checks never depend on when the agent answers.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int unsigned LREG_W = 5;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_OUT    = 2'd1,
    RG_LOCAL  = 2'd2,
    RG_IN     = 2'd3
  } rwin_region_e;

  // Classify a logical register number given the bank sizes.
  function automatic rwin_region_e region_of(input int unsigned lr,
                                             input int unsigned n_glb,
                                             input int unsigned n_out,
                                             input int unsigned n_loc);
    if (lr < n_glb)                      return RG_GLOBAL;
    else if (lr < n_glb + n_out)         return RG_OUT;
    else if (lr < n_glb + n_out + n_loc) return RG_LOCAL;
    else                                 return RG_IN;
  endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int unsigned N_WIN = 8,
  parameter int unsigned N_GLB = 10,
  parameter int unsigned N_OUT = 6,
  parameter int unsigned N_LOC = 10,
  parameter int unsigned PTR_W = 3,
  parameter int unsigned PHY_W = 8
) (
  input  logic [LREG_W-1:0] lreg,
  input  logic [PTR_W-1:0]  win,
  output logic [PHY_W-1:0]  pidx,
  output logic              is_zero
);
  localparam int unsigned SPAN     = N_OUT + N_LOC;
  localparam int unsigned OUT_BASE = N_GLB;
  localparam int unsigned LOC_BASE = N_GLB + N_OUT;
  localparam int unsigned IN_BASE  = N_GLB + N_OUT + N_LOC;

  int unsigned lr_u;
  int unsigned w_u;
  int unsigned wn_u;
  int unsigned idx;
  rwin_region_e rg;

  always_comb begin
    lr_u = int'(lreg);
    w_u  = int'(win);
    wn_u = (w_u == N_WIN - 1) ? 0 : w_u + 1;
    rg   = region_of(lr_u, N_GLB, N_OUT, N_LOC);
    unique case (rg)
      RG_GLOBAL: idx = lr_u;
      // outgoing arguments live in the slice of the next window
      RG_OUT:    idx = N_GLB + wn_u * SPAN + (lr_u - OUT_BASE);
      RG_LOCAL:  idx = N_GLB + w_u * SPAN + N_OUT + (lr_u - LOC_BASE);
      default:   idx = N_GLB + w_u * SPAN + (lr_u - IN_BASE);
    endcase
    pidx    = PHY_W'(idx);
    is_zero = (lreg == '0);
  end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int unsigned N_WIN = 8,
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             spill_ack_i,
  input  logic             fill_ack_i,
  output logic [PTR_W-1:0] cwp_o,
  output logic [PTR_W-1:0] swp_o,
  output logic             spill_req_o,
  output logic             fill_req_o
);
  function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(N_WIN - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ring_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(N_WIN - 1) : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] cwp_q, swp_q;
  logic             spill_q, fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q   <= '0;
      swp_q   <= '0;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else if (spill_q) begin
      if (spill_ack_i) begin
        spill_q <= 1'b0;
        swp_q   <= ring_inc(swp_q);
        cwp_q   <= ring_inc(cwp_q);
      end
    end else if (fill_q) begin
      if (fill_ack_i) begin
        fill_q <= 1'b0;
        swp_q  <= ring_dec(swp_q);
        cwp_q  <= ring_dec(cwp_q);
      end
    end else if (call_i) begin
      if (ring_inc(cwp_q) == swp_q) spill_q <= 1'b1;
      else                          cwp_q   <= ring_inc(cwp_q);
    end else if (ret_i) begin
      if (cwp_q == swp_q) fill_q <= 1'b1;
      else                cwp_q  <= ring_dec(cwp_q);
    end
  end

  assign cwp_o       = cwp_q;
  assign swp_o       = swp_q;
  assign spill_req_o = spill_q;
  assign fill_req_o  = fill_q;

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_PHYS = 138,
  parameter int unsigned PHY_W  = 8,
  parameter int unsigned N_RD   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [PHY_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [N_RD-1:0][PHY_W-1:0]  rd_idx,
  input  logic [N_RD-1:0]             rd_zero,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [N_PHYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (rd_zero[p])                    q <= '0;
      else if (wr_en && wr_idx == rd_idx[p])  q <= wr_data;
      else                                    q <= mem[rd_idx[p]];
    end
    assign rd_data[p] = q;
  end

endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned N_WIN  = 8,
  parameter  int unsigned N_GLB  = 10,
  parameter  int unsigned N_OUT  = 6,
  parameter  int unsigned N_LOC  = 10,
  localparam int unsigned PTR_W  = (N_WIN > 1) ? $clog2(N_WIN) : 1,
  localparam int unsigned N_PHYS = N_GLB + N_WIN * (N_OUT + N_LOC),
  localparam int unsigned PHY_W  = $clog2(N_PHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              spill_ack_i,
  input  logic              fill_ack_i,
  input  logic [LREG_W-1:0] rs1_i,
  input  logic [LREG_W-1:0] rs2_i,
  input  logic [LREG_W-1:0] rd_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rdata1_o,
  output logic [DATA_W-1:0] rdata2_o,
  output logic [PTR_W-1:0]  cwp_o,
  output logic [PTR_W-1:0]  swp_o,
  output logic              spill_req_o,
  output logic              fill_req_o
);
  localparam int unsigned N_ADDR = 3;  // two reads, one write

  logic [LREG_W-1:0] lr   [N_ADDR];
  logic [PHY_W-1:0]  pidx [N_ADDR];
  logic              zero [N_ADDR];

  assign lr[0] = rs1_i;
  assign lr[1] = rs2_i;
  assign lr[2] = rd_i;

  for (genvar a = 0; a < N_ADDR; a++) begin : g_map
    rwin_map #(
      .N_WIN(N_WIN), .N_GLB(N_GLB), .N_OUT(N_OUT), .N_LOC(N_LOC),
      .PTR_W(PTR_W), .PHY_W(PHY_W)
    ) u_map (
      .lreg   (lr[a]),
      .win    (cwp_o),
      .pidx   (pidx[a]),
      .is_zero(zero[a])
    );
  end

  rwin_ctrl #(.N_WIN(N_WIN), .PTR_W(PTR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .spill_ack_i(spill_ack_i),
    .fill_ack_i (fill_ack_i),
    .cwp_o      (cwp_o),
    .swp_o      (swp_o),
    .spill_req_o(spill_req_o),
    .fill_req_o (fill_req_o)
  );

  logic [1:0][PHY_W-1:0]  rd_idx;
  logic [1:0]             rd_zero;
  logic [1:0][DATA_W-1:0] rd_data;

  assign rd_idx  = {pidx[1], pidx[0]};
  assign rd_zero = {zero[1], zero[0]};

  rwin_store #(
    .DATA_W(DATA_W), .N_PHYS(N_PHYS), .PHY_W(PHY_W), .N_RD(2)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (we_i && !zero[2]),
    .wr_idx (pidx[2]),
    .wr_data(wd_i),
    .rd_idx (rd_idx),
    .rd_zero(rd_zero),
    .rd_data(rd_data)
  );

  assign rdata1_o = rd_data[0];
  assign rdata2_o = rd_data[1];

endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_WIN  = 8,
  parameter int unsigned PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              call_i,
  input logic              ret_i,
  input logic              spill_ack_i,
  input logic              fill_ack_i,
  input logic [4:0]        rs1_i,
  input logic [4:0]        rd_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wd_i,
  input logic [DATA_W-1:0] rdata1_o,
  input logic [PTR_W-1:0]  cwp_o,
  input logic [PTR_W-1:0]  swp_o,
  input logic              spill_req_o,
  input logic              fill_req_o
);
  function automatic logic [PTR_W-1:0] nx(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(N_WIN - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PTR_W-1:0] pv(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(N_WIN - 1) : p - 1'b1;
  endfunction

  logic pend;
  assign pend = spill_req_o || fill_req_o;

  p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
    rs1_i == 5'd0 |=> rdata1_o == '0);

  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (we_i && rd_i != 5'd0 && rd_i == rs1_i) |=> rdata1_o == $past(wd_i));

  p_call_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!pend && call_i && nx(cwp_o) != swp_o) |=> cwp_o == nx($past(cwp_o)));

  p_ret_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!pend && !call_i && ret_i && cwp_o != swp_o) |=> cwp_o == pv($past(cwp_o)));

  p_spill_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (!pend && call_i && nx(cwp_o) == swp_o) |=> spill_req_o && $stable(cwp_o));

  p_spill_done_r8: assert property (@(posedge clk) disable iff (rst)
    (spill_req_o && spill_ack_i) |=> !spill_req_o && swp_o == nx($past(swp_o))
                                     && cwp_o == nx($past(cwp_o)));

  p_fill_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (!pend && !call_i && ret_i && cwp_o == swp_o) |=> fill_req_o && $stable(cwp_o));

  p_fill_done_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_req_o && fill_ack_i) |=> !fill_req_o && swp_o == pv($past(swp_o))
                                   && cwp_o == swp_o);

  p_req_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(spill_req_o && fill_req_o));

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    ((spill_req_o && !spill_ack_i) || (fill_req_o && !fill_ack_i))
      |=> $stable(cwp_o) && $stable(swp_o));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!pend && !call_i && !ret_i) |=> $stable(cwp_o) && $stable(swp_o) && !pend);

endmodule

bind rwin_file rwin_file_chk #(.DATA_W(DATA_W), .N_WIN(N_WIN), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
  .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i),
  .rs1_i(rs1_i), .rd_i(rd_i), .we_i(we_i), .wd_i(wd_i),
  .rdata1_o(rdata1_o), .cwp_o(cwp_o), .swp_o(swp_o),
  .spill_req_o(spill_req_o), .fill_req_o(fill_req_o)
);

// File: tb/sim_rwin_file.sv
module sim_rwin_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, spill_ack_i = 0, fill_ack_i = 0;
  logic [4:0]  rs1_i = 0, rs2_i = 0, rd_i = 0;
  logic        we_i = 0;
  logic [31:0] wd_i = 0;
  logic [31:0] rdata1_o, rdata2_o;
  logic [2:0]  cwp_o, swp_o;
  logic        spill_req_o, fill_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;  // 100 MHz

  rwin_file u0 (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .rd_i(rd_i), .we_i(we_i), .wd_i(wd_i),
    .rdata1_o(rdata1_o), .rdata2_o(rdata2_o), .cwp_o(cwp_o), .swp_o(swp_o),
    .spill_req_o(spill_req_o), .fill_req_o(fill_req_o)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CALL = 2'd2, OP_RET = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  lr;
    logic [31:0] val;  // write data, expected read data, or expected cwp
  } vec_t;

  localparam int N_VEC = 17;
  localparam vec_t VECS [N_VEC] = '{
    '{OP_WR,   5'd1,  32'h0000_0011},  // global
    '{OP_WR,   5'd10, 32'h0000_00A0},  // out0 of window 0
    '{OP_WR,   5'd16, 32'h0000_0160},  // local0 of window 0
    '{OP_WR,   5'd26, 32'h0000_0260},  // in0 of window 0
    '{OP_WR,   5'd15, 32'h0000_00F5},  // out5 of window 0
    '{OP_CALL, 5'd0,  32'd1},          // R7
    '{OP_RD,   5'd26, 32'h0000_00A0},  // R5 caller out0 = callee in0
    '{OP_RD,   5'd31, 32'h0000_00F5},  // R5 out5 = in5
    '{OP_RD,   5'd1,  32'h0000_0011},  // R3 global visible
    '{OP_WR,   5'd16, 32'h0000_0161},  // callee local0
    '{OP_WR,   5'd27, 32'h0000_0271},  // callee in1
    '{OP_RET,  5'd0,  32'd0},          // R7
    '{OP_RD,   5'd16, 32'h0000_0160},  // R4 local survives
    '{OP_RD,   5'd11, 32'h0000_0271},  // R5 reverse direction
    '{OP_RD,   5'd26, 32'h0000_0260},  // R4/R5 own ins untouched
    '{OP_WR,   5'd0,  32'h0000_DEAD},  // R2 write to zero
    '{OP_RD,   5'd0,  32'h0000_0000}   // R2 reads zero
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ptrs(input string tag, input logic [2:0] c, input logic [2:0] s,
                            input logic sp, input logic fl);
    check({tag, " cwp"},   {29'd0, cwp_o}, {29'd0, c});
    check({tag, " swp"},   {29'd0, swp_o}, {29'd0, s});
    check({tag, " spill"}, {31'd0, spill_req_o}, {31'd0, sp});
    check({tag, " fill"},  {31'd0, fill_req_o},  {31'd0, fl});
  endtask

  task automatic do_call();
    call_i = 1; step(); call_i = 0;
  endtask
  task automatic do_ret();
    ret_i = 1; step(); ret_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R1 reset state
    check_ptrs("R1 reset", 3'd0, 3'd0, 1'b0, 1'b0);
    check("R1 rdata1", rdata1_o, 32'd0);
    check("R1 rdata2", rdata2_o, 32'd0);

    // vector table walk (R2 R3 R4 R5 R7)
    for (int i = 0; i < N_VEC; i++) begin
      case (VECS[i].op)
        OP_WR: begin
          rd_i = VECS[i].lr; wd_i = VECS[i].val; we_i = 1;
          step(); we_i = 0;
        end
        OP_RD: begin
          rs1_i = VECS[i].lr; rs2_i = VECS[i].lr;
          step();
          check($sformatf("table row %0d port1", i), rdata1_o, VECS[i].val);
          check($sformatf("table row %0d port2", i), rdata2_o, VECS[i].val);
        end
        OP_CALL: begin
          do_call();
          check($sformatf("R7 table row %0d call", i), {29'd0, cwp_o}, VECS[i].val);
        end
        default: begin
          do_ret();
          check($sformatf("R7 table row %0d ret", i), {29'd0, cwp_o}, VECS[i].val);
        end
      endcase
    end

    // R6 same-cycle write and read forward the new data
    rs1_i = 5'd5; rs2_i = 5'd5; rd_i = 5'd5; wd_i = 32'h55; we_i = 1;
    step(); we_i = 0;
    check("R6 bypass port1", rdata1_o, 32'h55);
    check("R6 bypass port2", rdata2_o, 32'h55);
    // R6 registered read: output changes only after the edge
    rs1_i = 5'd1; #2;
    check("R6 read held before edge", rdata1_o, 32'h55);
    step();
    check("R6 read after edge", rdata1_o, 32'h11);

    // R7 seven calls fill the ring without a spill
    for (int k = 1; k <= 7; k++) begin
      do_call();
      check_ptrs($sformatf("R7 call %0d", k), 3'(k), 3'd0, 1'b0, 1'b0);
    end
    // R8 eighth call needs a spill
    do_call();
    check_ptrs("R8 spill raised", 3'd7, 3'd0, 1'b1, 1'b0);
    // R10 call ignored while pending
    do_call();
    check_ptrs("R10 call while spill", 3'd7, 3'd0, 1'b1, 1'b0);
    spill_ack_i = 1; step(); spill_ack_i = 0;
    check_ptrs("R8 spill done wrap", 3'd0, 3'd1, 1'b0, 1'b0);

    // R11 stray acknowledges
    fill_ack_i = 1; step(); fill_ack_i = 0;
    check_ptrs("R11 stray fill ack", 3'd0, 3'd1, 1'b0, 1'b0);
    spill_ack_i = 1; step(); spill_ack_i = 0;
    check_ptrs("R11 stray spill ack", 3'd0, 3'd1, 1'b0, 1'b0);

    // R7 returns wrap downward to window 1
    do_ret();
    check_ptrs("R7 ret wrap", 3'd7, 3'd1, 1'b0, 1'b0);
    for (int k = 6; k >= 1; k--) begin
      do_ret();
      check_ptrs($sformatf("R7 ret to %0d", k), 3'(k), 3'd1, 1'b0, 1'b0);
    end
    // R9 return below oldest resident window
    do_ret();
    check_ptrs("R9 fill raised", 3'd1, 3'd1, 1'b0, 1'b1);
    do_ret();
    check_ptrs("R10 ret while fill", 3'd1, 3'd1, 1'b0, 1'b1);
    fill_ack_i = 1; step(); fill_ack_i = 0;
    check_ptrs("R9 fill done", 3'd0, 3'd0, 1'b0, 1'b0);

    // R10 call wins over simultaneous return
    call_i = 1; ret_i = 1; step(); call_i = 0; ret_i = 0;
    check_ptrs("R10 call beats ret", 3'd1, 3'd0, 1'b0, 1'b0);
    do_ret();
    check_ptrs("R7 back to 0", 3'd0, 3'd0, 1'b0, 1'b0);

    // R1 reset clears a pending fill
    do_ret();
    check_ptrs("R9 fill at base", 3'd0, 3'd0, 1'b0, 1'b1);
    rs1_i = 5'd1; rst = 1; step(); rst = 0;
    check_ptrs("R1 reset mid-request", 3'd0, 3'd0, 1'b0, 1'b0);
    check("R1 rdata1 after reset", rdata1_o, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule